// File: doc/BRIEF.md
# Pipelined Multiply-Shift Unit with Register Interlock

A 32-bit execution unit for a small in-order core. It performs multiply, logical left shift, logical and arithmetic right shift, and left rotate. All of these run through one three-stage pipelined multiplier. For a shift or rotate, the shift amount is first turned into a power-of-two multiplicand. A left shift keeps the low half of the product. A right shift by n multiplies by 2^(32-n) and keeps the high half. A rotate ORs the two halves together.

Each cycle the issue port presents either a unit operation or a plain single-cycle instruction, together with its two source register numbers and its destination register number. A pending-bit scoreboard holds back an instruction that names a register whose unit result has not yet reached writeback. Instructions that do not depend on such a register issue back to back. Results leave through a writeback port that carries a tag (the destination register) and a value.

Top module: `mulshift_unit`

## Requirements
- R1: A unit operation accepted in cycle t (issue_valid_i high and stall_o low in that cycle) appears on the writeback port in cycle t+3, with wb_valid_o high and wb_tag_o equal to its destination register. wb_valid_o is never high without such an acceptance.
- R2: Independent unit operations can be accepted in consecutive cycles, and their results are written back in consecutive cycles in issue order.
- R3: stall_o is high only while issue_valid_i is high. It is high when src_a_i or src_b_i names a register with an unfinished unit result. It drops in the cycle that the result appears on writeback. For a dependent instruction that immediately follows its producer, this means exactly two stall cycles, and the dependent instruction is accepted three cycles after the producer.
- R4: An instruction whose registers have no unfinished result is accepted without stalling. Three independent unit operations followed by an instruction that reads the first one's destination cause no stall.
- R5: An instruction, of either kind, whose destination register has an unfinished unit result stalls until that result is written back.
- R6: Register 0 is never marked pending. A unit operation with destination 0 still writes back with tag 0, but it never causes a stall.
- R7: op_i = 0 (multiply) returns the low 32 bits of the unsigned product opa_i*opb_i.
- R8: op_i = 1 (logical left shift) returns opa_i shifted left by n. op_i = 4 (left rotate) returns opa_i rotated left by n.
- R9: op_i = 2 (logical right shift) returns opa_i shifted right by n with zero fill. op_i = 3 (arithmetic right shift) fills the vacated bits with opa_i[31].
- R10: n is opb_i[4:0], and the upper bits of opb_i are ignored. With n = 0, every shift and rotate returns opa_i unchanged.
- R11: While an instruction is stalled and held at the input, operations already in the pipeline keep advancing and write back on time.
- R12: After reset, wb_valid_o is low and no register is pending.
- R13: A plain instruction (is_alu_i = 1) produces no writeback and marks no register pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | An instruction is presented |
| is_alu_i | input | 1 | 1: plain single-cycle instruction; 0: unit operation |
| op_i | input | 3 | 0 multiply, 1 left shift, 2 logical right, 3 arithmetic right, 4 left rotate |
| src_a_i | input | 5 | First source register |
| src_b_i | input | 5 | Second source register |
| dst_i | input | 5 | Destination register |
| opa_i | input | 32 | Multiplicand, or the value to be shifted |
| opb_i | input | 32 | Multiplier, or the shift amount in bits [4:0] |
| stall_o | output | 1 | The presented instruction is held this cycle |
| wb_valid_o | output | 1 | A writeback is present |
| wb_tag_o | output | 5 | Destination register of the writeback |
| wb_data_o | output | 32 | Result value |

## Verification
The bench counts stall cycles for a dependent instruction placed right behind its producer. It expects exactly two: a design that releases one cycle early would let a stale value through, and one that waits for the pending bit to clear would cost an extra cycle. It places three independent multiplies ahead of a consumer, and it stalls on a register while an older operation completes. A scoreboard that blocks too broadly, or a pipeline that freezes during a stall, would show up as extra stalls or late writebacks. On the data side it covers shift amounts 0, 1, 31, 32 and 33, and arithmetic shifts of negative values. It also runs a write-after-write pair and a writeback to register 0. A missing n = 0 bypass on right shifts would return zero, a wrong fill mask would corrupt the sign bits, and a pending bit set for register 0 would stall every later instruction.

// File: rtl/mulshift_pkg.sv
package mulshift_pkg;
  typedef enum logic [2:0] {
    OP_MUL = 3'd0,
    OP_SLL = 3'd1,
    OP_SRL = 3'd2,
    OP_SRA = 3'd3,
    OP_ROL = 3'd4
  } ms_op_e;
endpackage

// File: rtl/mulshift_prep.sv
module mulshift_prep
  import mulshift_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SH_W = $clog2(XLEN),
  localparam int SELW = SH_W + 1
) (
  input  ms_op_e          op_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] mcand_o,
  output logic            pass_o
);
  logic [SH_W-1:0] amt;
  logic            is_shift, is_right;
  logic [SELW-1:0] sel;

  assign amt      = opb_i[SH_W-1:0];
  assign is_shift = (op_i != OP_MUL);
  assign is_right = (op_i == OP_SRL) || (op_i == OP_SRA);
  assign sel      = is_right ? (SELW'(XLEN) - {1'b0, amt}) : {1'b0, amt};
  // right shift by zero would need 2^XLEN: bypass instead
  assign pass_o   = is_right && (amt == '0);

  always_comb begin
    if (!is_shift) begin
      mcand_o = opb_i;
    end else begin
      for (int k = 0; k < XLEN; k++) mcand_o[k] = (sel == SELW'(k));
    end
  end
endmodule

// File: rtl/mulshift_pipe.sv
module mulshift_pipe
  import mulshift_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  ms_op_e           in_op_i,
  input  logic [XLEN-1:0]  in_a_i,
  input  logic [XLEN-1:0]  in_m_i,
  input  logic             in_pass_i,
  input  logic [REG_W-1:0] in_tag_i,
  output logic             out_valid_o,
  output logic [REG_W-1:0] out_tag_o,
  output logic [XLEN-1:0]  out_data_o
);
  localparam int PW = 2 * XLEN;

  logic             v1, v2;
  ms_op_e           op1, op2;
  logic [XLEN-1:0]  a1, a2, m1, m2;
  logic             p1, p2;
  logic [REG_W-1:0] t1, t2;
  logic [PW-1:0]    prod2;
  logic [XLEN-1:0]  lo, hi, fill, res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      out_valid_o <= 1'b0;
    end else begin
      v1 <= in_valid_i;
      v2 <= v1;
      out_valid_o <= v2;
    end
  end

  always_ff @(posedge clk_i) begin
    op1 <= in_op_i;
    a1  <= in_a_i;
    m1  <= in_m_i;
    p1  <= in_pass_i;
    t1  <= in_tag_i;
    op2   <= op1;
    a2    <= a1;
    m2    <= m1;
    p2    <= p1;
    t2    <= t1;
    prod2 <= {{XLEN{1'b0}}, a1} * {{XLEN{1'b0}}, m1};
    out_tag_o  <= t2;
    out_data_o <= res;
  end

  assign lo   = prod2[XLEN-1:0];
  assign hi   = prod2[PW-1:XLEN];
  // two's complement of 2^(XLEN-n) = top n bits set
  assign fill = a2[XLEN-1] ? (~m2 + {{(XLEN-1){1'b0}}, 1'b1}) : '0;

  always_comb begin
    unique case (op2)
      OP_MUL, OP_SLL: res = lo;
      OP_ROL:         res = lo | hi;
      OP_SRL:         res = p2 ? a2 : hi;
      OP_SRA:         res = p2 ? a2 : (hi | fill);
      default:        res = lo;
    endcase
  end
endmodule

// File: rtl/mulshift_scoreboard.sv
module mulshift_scoreboard #(
  parameter int NREG  = 32,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [REG_W-1:0] set_idx_i,
  input  logic             clr_i,
  input  logic [REG_W-1:0] clr_idx_i,
  output logic [NREG-1:0]  pend_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    if (r == 0) begin : g_zero
      assign pend_o[r] = 1'b0;
    end else begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_o[r] <= 1'b0;
        else if (set_i && set_idx_i == REG_W'(r)) pend_o[r] <= 1'b1;
        else if (clr_i && clr_idx_i == REG_W'(r)) pend_o[r] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mulshift_unit.sv
module mulshift_unit
  import mulshift_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int REG_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_valid_i,
  input  logic             is_alu_i,
  input  logic [2:0]       op_i,
  input  logic [REG_W-1:0] src_a_i,
  input  logic [REG_W-1:0] src_b_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  output logic             stall_o,
  output logic             wb_valid_o,
  output logic [REG_W-1:0] wb_tag_o,
  output logic [XLEN-1:0]  wb_data_o
);
  logic [NREG-1:0] pend;
  logic [XLEN-1:0] mcand;
  logic            pass;
  logic            acc_unit;
  logic            busy_a, busy_b, busy_d;
  ms_op_e          op;

  assign op = ms_op_e'(op_i);

  // a pending register is released in the cycle its result is on writeback
  function automatic logic busy(input logic [REG_W-1:0] r);
    return pend[r] && !(wb_valid_o && wb_tag_o == r);
  endfunction

  assign busy_a   = busy(src_a_i);
  assign busy_b   = busy(src_b_i);
  assign busy_d   = busy(dst_i);
  assign stall_o  = issue_valid_i && (busy_a || busy_b || busy_d);
  assign acc_unit = issue_valid_i && !stall_o && !is_alu_i;

  mulshift_scoreboard #(.NREG(NREG)) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (acc_unit),
    .set_idx_i (dst_i),
    .clr_i     (wb_valid_o),
    .clr_idx_i (wb_tag_o),
    .pend_o    (pend)
  );

  mulshift_prep #(.XLEN(XLEN)) u_prep (
    .op_i    (op),
    .opb_i   (opb_i),
    .mcand_o (mcand),
    .pass_o  (pass)
  );

  mulshift_pipe #(.XLEN(XLEN), .REG_W(REG_W)) u_pipe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (acc_unit),
    .in_op_i     (op),
    .in_a_i      (opa_i),
    .in_m_i      (mcand),
    .in_pass_i   (pass),
    .in_tag_i    (dst_i),
    .out_valid_o (wb_valid_o),
    .out_tag_o   (wb_tag_o),
    .out_data_o  (wb_data_o)
  );
endmodule

// File: rtl/mulshift_checker.sv
module mulshift_checker #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int REG_W = $clog2(NREG)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             issue_valid_i,
  input logic             is_alu_i,
  input logic [REG_W-1:0] src_a_i,
  input logic [REG_W-1:0] src_b_i,
  input logic [REG_W-1:0] dst_i,
  input logic             stall_o,
  input logic             wb_valid_o,
  input logic [REG_W-1:0] wb_tag_o
);
  logic acc_u;
  assign acc_u = issue_valid_i && !stall_o && !is_alu_i;

  AST_WB_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acc_u, 3) |-> (wb_valid_o && wb_tag_o == $past(dst_i, 3))); // R1

  AST_WB_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> $past(acc_u, 3)); // R1

  AST_STALL_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> issue_valid_i); // R3

  AST_DEP_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(acc_u && dst_i != '0) && issue_valid_i &&
     (src_a_i == $past(dst_i) || src_b_i == $past(dst_i))) |-> stall_o); // R3

  AST_WAW_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(acc_u && dst_i != '0) && issue_valid_i && dst_i == $past(dst_i)) |-> stall_o); // R5

  AST_R0_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && src_a_i == '0 && src_b_i == '0 && dst_i == '0) |-> !stall_o); // R6
endmodule

bind mulshift_unit mulshift_checker #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_i),
  .is_alu_i      (is_alu_i),
  .src_a_i       (src_a_i),
  .src_b_i       (src_b_i),
  .dst_i         (dst_i),
  .stall_o       (stall_o),
  .wb_valid_o    (wb_valid_o),
  .wb_tag_o      (wb_tag_o)
);

// File: tb/tb_mulshift_unit.sv
`timescale 1ns/1ps
module tb_mulshift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iv = 1'b0, alu = 1'b0;
  logic [2:0]  op = '0;
  logic [4:0]  sa = '0, sb = '0, dd = '0;
  logic [31:0] a = '0, b = '0;
  logic        stall, wbv;
  logic [4:0]  wbt;
  logic [31:0] wbd;

  mulshift_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .issue_valid_i(iv), .is_alu_i(alu), .op_i(op),
    .src_a_i(sa), .src_b_i(sb), .dst_i(dd), .opa_i(a), .opb_i(b),
    .stall_o(stall), .wb_valid_o(wbv), .wb_tag_o(wbt), .wb_data_o(wbd)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [4:0]  q_tag  [64];
  logic [31:0] q_data [64];
  int          q_due  [64];
  string       q_req  [64];
  int          q_hd = 0, q_tl = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] x,
                                        input logic [31:0] y);
    int n;
    n = int'(y[4:0]);
    case (o)
      3'd0: return x * y;
      3'd1: return x << n;
      3'd2: return x >> n;
      3'd3: return $unsigned($signed(x) >>> n);
      3'd4: return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
      default: return '0;
    endcase
  endfunction

  // writeback monitor: value, tag and cycle of every result
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wbv) begin
        if (q_hd == q_tl) check(1'b0, "R1", "writeback with nothing issued", 32'(wbt), 32'hx);
        else begin
          check(cyc == q_due[q_hd % 64], q_req[q_hd % 64], "writeback cycle",
                32'(cyc), 32'(q_due[q_hd % 64]));
          check(wbt == q_tag[q_hd % 64], q_req[q_hd % 64], "writeback tag",
                32'(wbt), 32'(q_tag[q_hd % 64]));
          check(wbd == q_data[q_hd % 64], q_req[q_hd % 64], "writeback data",
                wbd, q_data[q_hd % 64]);
          q_hd++;
        end
      end else if (q_hd != q_tl && cyc > q_due[q_hd % 64]) begin
        check(1'b0, q_req[q_hd % 64], "missing writeback", 32'(cyc), 32'(q_due[q_hd % 64]));
        q_hd++;
      end
    end
  end

  task automatic issue(input bit k_alu, input logic [2:0] o, input logic [4:0] ra,
                       input logic [4:0] rb, input logic [4:0] rd, input logic [31:0] x,
                       input logic [31:0] y, input string req,
                       output int stalls, output int acc_cyc);
    @(negedge clk);
    iv = 1'b1; alu = k_alu; op = o; sa = ra; sb = rb; dd = rd; a = x; b = y;
    stalls = 0;
    #1;
    while (stall) begin
      stalls++;
      @(negedge clk);
      #1;
      if (stalls > 20) break;
    end
    acc_cyc = cyc;
    if (!k_alu) begin
      q_tag[q_tl % 64]  = rd;
      q_data[q_tl % 64] = model(o, x, y);
      q_due[q_tl % 64]  = cyc + 3;
      q_req[q_tl % 64]  = req;
      q_tl++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      iv = 1'b0;
    end
  endtask

  task automatic unit_op(input logic [2:0] o, input logic [4:0] rd, input logic [31:0] x,
                         input logic [31:0] y, input string req);
    int s, c;
    issue(1'b0, o, 5'd0, 5'd0, rd, x, y, req, s, c);
    check(s == 0, req, "unexpected stall", 32'(s), 0);
  endtask

  task automatic t_reset();
    int s, c;
    check(wbv == 1'b0, "R12", "wb_valid after reset", 32'(wbv), 0);
    issue(1'b1, 3'd0, 5'd5, 5'd17, 5'd31, 0, 0, "R12", s, c);
    check(s == 0, "R12", "stall on fresh scoreboard", 32'(s), 0);
    idle(2);
    check(wbv == 1'b0, "R13", "plain instruction wrote back", 32'(wbv), 0);
  endtask

  task automatic t_mul();
    unit_op(3'd0, 5'd1, 32'h1234_5678, 32'h9abc_def0, "R7");
    unit_op(3'd0, 5'd2, 32'hffff_ffff, 32'hffff_ffff, "R7");
    unit_op(3'd0, 5'd3, 32'd7, 32'd6, "R1");
    idle(5);
  endtask

  task automatic t_dep();
    int s, c0, c1;
    issue(1'b0, 3'd0, 5'd0, 5'd0, 5'd5, 32'd9, 32'd11, "R3", s, c0);
    issue(1'b1, 3'd0, 5'd0, 5'd5, 5'd6, 0, 0, "R3", s, c1);
    check(s == 2, "R3", "dependent stall cycles", 32'(s), 2);
    check(c1 - c0 == 3, "R3", "dependent issue distance", 32'(c1 - c0), 3);
    idle(5);
  endtask

  task automatic t_indep();
    int s, c;
    unit_op(3'd0, 5'd6, 32'd3, 32'd4, "R4");
    unit_op(3'd0, 5'd7, 32'd5, 32'd6, "R4");
    unit_op(3'd0, 5'd8, 32'd7, 32'd8, "R4");
    issue(1'b1, 3'd0, 5'd6, 5'd0, 5'd9, 0, 0, "R4", s, c);
    check(s == 0, "R4", "stall after three independent ops", 32'(s), 0);
    idle(5);
  endtask

  task automatic t_thru();
    int s, c, cp;
    cp = -1;
    for (int i = 0; i < 4; i++) begin
      issue(1'b0, 3'd1, 5'd0, 5'd0, 5'(10 + i), 32'h0000_00f1 << i, 32'(i + 3), "R2", s, c);
      if (cp >= 0) check(c - cp == 1, "R2", "back-to-back issue", 32'(c - cp), 1);
      cp = c;
    end
    idle(5);
  endtask

  task automatic t_shifts();
    unit_op(3'd1, 5'd1, 32'h8000_0001, 32'd1,  "R8");
    unit_op(3'd1, 5'd2, 32'h0000_0003, 32'd31, "R8");
    unit_op(3'd4, 5'd3, 32'h8000_0001, 32'd1,  "R8");
    unit_op(3'd4, 5'd4, 32'hdead_beef, 32'd31, "R8");
    unit_op(3'd4, 5'd5, 32'h1234_5678, 32'd16, "R8");
    unit_op(3'd2, 5'd6, 32'h8000_0000, 32'd31, "R9");
    unit_op(3'd2, 5'd7, 32'hf0f0_f0f0, 32'd4,  "R9");
    unit_op(3'd3, 5'd8, 32'h8000_0000, 32'd31, "R9");
    unit_op(3'd3, 5'd9, 32'hf0f0_f0f0, 32'd4,  "R9");
    unit_op(3'd3, 5'd10, 32'h7000_0000, 32'd1, "R9");
    unit_op(3'd3, 5'd11, 32'h8000_1234, 32'd1, "R9");
    idle(5);
  endtask

  task automatic t_amount();
    for (int o = 1; o <= 4; o++)
      unit_op(3'(o), 5'(o), 32'h9234_5679, 32'hffff_ffe0, "R10"); // n=0, upper bits set
    unit_op(3'd1, 5'd5, 32'h0000_0005, 32'd33, "R10");
    unit_op(3'd3, 5'd6, 32'h8000_0000, 32'd33, "R10");
    unit_op(3'd2, 5'd7, 32'hcafe_f00d, 32'd32, "R10");
    idle(5);
  endtask

  task automatic t_r0();
    int s, c;
    unit_op(3'd0, 5'd0, 32'd21, 32'd2, "R6");
    issue(1'b1, 3'd0, 5'd0, 5'd0, 5'd0, 0, 0, "R6", s, c);
    check(s == 0, "R6", "stall on register 0", 32'(s), 0);
    issue(1'b0, 3'd1, 5'd0, 5'd0, 5'd0, 32'd1, 32'd4, "R6", s, c);
    check(s == 0, "R6", "unit op to register 0 stalled", 32'(s), 0);
    idle(5);
  endtask

  task automatic t_waw();
    int s, c0, c1;
    issue(1'b0, 3'd0, 5'd0, 5'd0, 5'd12, 32'd100, 32'd3, "R5", s, c0);
    issue(1'b0, 3'd1, 5'd0, 5'd0, 5'd12, 32'd1, 32'd7, "R5", s, c1);
    check(s == 2, "R5", "write-after-write stall cycles", 32'(s), 2);
    idle(1);
    issue(1'b1, 3'd0, 5'd0, 5'd0, 5'd12, 0, 0, "R5", s, c1);
    check(s == 1, "R5", "plain instruction on pending dst", 32'(s), 1);
    idle(5);
  endtask

  task automatic t_adv();
    int s, c;
    unit_op(3'd0, 5'd13, 32'd123, 32'd456, "R11");
    unit_op(3'd2, 5'd14, 32'h8000_0000, 32'd3, "R11");
    issue(1'b1, 3'd0, 5'd14, 5'd0, 5'd15, 0, 0, "R11", s, c);
    check(s == 2, "R11", "stall while older op completes", 32'(s), 2);
    idle(5);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      check(q_hd == q_tl, "R1", "results left outstanding", 32'(q_tl - q_hd), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_mul();
    t_dep();
    t_indep();
    t_thru();
    t_shifts();
    t_amount();
    t_r0();
    t_waw();
    t_adv();
    idle(2);
    finish_run();
  end
endmodule